// File: doc/BRIEF.md
# Interrupt Status Aggregator

This block gathers interrupt requests into one 10-bit status word and drives one interrupt line to the host. Four GPIO bank request lines appear live in the low status bits. Six other peripheral sources are captured as sticky flags in the bits above them. A mask word gives each source its own enable bit, plus a global enable. The host line is registered. It is high when the global enable is set and at least one enabled status bit is pending.

The host treats the line as rising-edge sensitive. After taking the interrupt, the host reads the status word to find the sources. It then writes ones to the sticky bits it has handled. Any status write that clears a sticky bit pulls the line low for one cycle. If requests are still pending after the service write, the line therefore gives a fresh rising edge.

A 16-bit register port with a single address bit selects the status word or the mask word. Reads are combinational. Writes take effect at the clock edge.

Top module: `irq_status_agg`

## Requirements
- R1: After reset, the mask word (all enables and the global enable) reads zero, all sticky status bits are zero, and `host_irq` is low.
- R2: With `reg_addr` = 0, `reg_rdata` bits 3..0 equal `bank_req` bits 3..0 in the same cycle. Bit 0 is bank A, bit 1 bank B, bit 2 bank C, bit 3 bank D.
- R3: A high `src_pulse[k]` at a clock edge sets status bit 4+k (k = 0..5). The bit stays set until it is cleared by R4.
- R4: A write to `reg_addr` = 0 clears each status bit 4..9 whose `reg_wdata` bit is 1. Bits written 0 are left unchanged, and written bits 3..0 and 15..10 have no effect. If a source pulses in the same cycle as its clear, the set wins.
- R5: A write to `reg_addr` = 1 loads the per-source enables from `reg_wdata` bits 9..0 (1 = enabled) and the global enable from bit 15. A read of `reg_addr` = 1 returns these bits, with bits 14..10 read as zero.
- R6: When no status write is made, `host_irq` in the cycle after an edge equals (global enable AND OR of (status & enables)), sampled just before that edge.
- R7: When the global enable is 0, `host_irq` goes low one cycle later and stays low whatever is pending.
- R8: A status write with any 1 in bits 9..4 forces `host_irq` low for the following cycle. If enabled requests are still pending, the line rises again one cycle after that.
- R9: With `reg_addr` = 0, `reg_rdata` bits 15..10 read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bank_req | input | 4 | Live request lines from GPIO banks A..D |
| src_pulse | input | 6 | Set requests from the six other sources |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 = status word, 1 = mask word |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data of the selected word |
| host_irq | output | 1 | Registered interrupt line to the host |

## Verification
The assertions check four things on every cycle:
- The bank bits mirror the bank lines, and the unused high status bits read zero.
- Sticky bits never drop without a status write.
- The line is low after a cycle with nothing pending, or with the global enable off.
- The line is low in the cycle after a clearing write.

The bench scenarios cover what the assertions cannot:
- The reset values.
- The mask readback.
- The set-beats-clear collision.
- The drop-then-rise sequence when requests remain after service.
- Agreement between the line and the masked status across long random runs.

// File: rtl/irq_status_agg.sv
module irq_status_agg #(
  parameter int NBANK   = 4,
  parameter int NOTHER  = 6,
  parameter int DW      = 16,
  parameter int GEN_BIT = DW - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NBANK-1:0]  bank_req,
  input  logic [NOTHER-1:0] src_pulse,
  input  logic              reg_we,
  input  logic              reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  output logic              host_irq
);
  localparam int NSRC = NBANK + NOTHER;

  logic [NOTHER-1:0] lat_q;
  logic [NSRC-1:0]   en_q;
  logic              gen_q;
  logic [NSRC-1:0]   status_vec;
  logic [DW-1:0]     st_word, mk_word;

  wire status_wr = reg_we && (reg_addr == 1'b0);
  wire mask_wr   = reg_we && (reg_addr == 1'b1);
  wire [NOTHER-1:0] clr_bits = status_wr ? reg_wdata[NSRC-1:NBANK] : '0;
  wire retrig = |clr_bits;

  assign status_vec = {lat_q, bank_req};
  wire any_pend = |(status_vec & en_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q <= '0;
    end else begin
      lat_q <= (lat_q & ~clr_bits) | src_pulse;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      gen_q <= 1'b0;
    end else if (mask_wr) begin
      en_q  <= reg_wdata[NSRC-1:0];
      gen_q <= reg_wdata[GEN_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      host_irq <= 1'b0;
    else if (retrig) host_irq <= 1'b0;
    else             host_irq <= gen_q && any_pend;
  end

  always_comb begin
    st_word = '0;
    st_word[NSRC-1:0] = status_vec;
    mk_word = '0;
    mk_word[NSRC-1:0] = en_q;
    mk_word[GEN_BIT] = gen_q;
  end

  assign reg_rdata = reg_addr ? mk_word : st_word;
endmodule

// File: rtl/irq_status_agg_chk.sv
module irq_status_agg_chk #(
  parameter int NBANK  = 4,
  parameter int NOTHER = 6,
  parameter int DW     = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NBANK-1:0]  bank_req,
  input logic              reg_we,
  input logic              reg_addr,
  input logic [DW-1:0]     reg_wdata,
  input logic [DW-1:0]     reg_rdata,
  input logic              host_irq,
  input logic [NOTHER-1:0] lat,
  input logic              pend,
  input logic              gen
);
  localparam int NSRC = NBANK + NOTHER;

  a_r2_bank_live: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 1'b0) |-> (reg_rdata[NBANK-1:0] == bank_req));

  a_r9_high_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 1'b0) |-> (reg_rdata[DW-1:NSRC] == '0));

  a_r3_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_we && reg_addr == 1'b0) |=> ((lat & $past(lat)) == $past(lat)));

  a_r6_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !pend |=> !host_irq);

  a_r7_gen_off: assert property (@(posedge clk) disable iff (!rst_n)
    !gen |=> !host_irq);

  a_r8_retrig: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 1'b0 && |reg_wdata[NSRC-1:NBANK]) |=> !host_irq);
endmodule

bind irq_status_agg irq_status_agg_chk #(.NBANK(NBANK), .NOTHER(NOTHER), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bank_req(bank_req), .reg_we(reg_we),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
  .host_irq(host_irq), .lat(lat_q), .pend(any_pend), .gen(gen_q)
);

// File: tb/irq_status_agg_test.sv
module irq_status_agg_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0]  bank_req = '0;
  logic [5:0]  src_pulse = '0;
  logic        reg_we = 1'b0;
  logic        reg_addr = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        host_irq;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  logic [5:0] m_lat;
  logic [9:0] m_en;
  logic       m_gen;
  logic       m_irq;

  always #5 clk = ~clk;

  irq_status_agg uut (
    .clk(clk), .rst_n(rst_n), .bank_req(bank_req), .src_pulse(src_pulse),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .host_irq(host_irq)
  );

  function automatic logic [15:0] exp_status(logic [5:0] lat, logic [3:0] bk);
    return {6'b0, lat, bk};
  endfunction

  function automatic logic [15:0] exp_mask(logic [9:0] en, logic g);
    return {g, 5'b0, en};
  endfunction

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic model_edge();
    logic [5:0] clr;
    logic nirq;
    clr = (reg_we && !reg_addr) ? reg_wdata[9:4] : 6'b0;
    if (|clr) nirq = 1'b0;
    else      nirq = m_gen && |({m_lat, bank_req} & m_en);
    m_lat = (m_lat & ~clr) | src_pulse;
    if (reg_we && reg_addr) begin
      m_en  = reg_wdata[9:0];
      m_gen = reg_wdata[15];
    end
    m_irq = nirq;
  endtask

  task automatic step(string tag);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    reg_we = 1'b0;
    src_pulse = '0;
    chk({tag, " irq"}, {15'b0, host_irq}, {15'b0, m_irq});
    chk({tag, " rdata"}, reg_rdata,
        reg_addr ? exp_mask(m_en, m_gen) : exp_status(m_lat, bank_req));
  endtask

  task automatic wr(logic a, logic [15:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7321));
    m_lat = '0; m_en = '0; m_gen = 1'b0; m_irq = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 irq", {15'b0, host_irq}, 16'h0);
    reg_addr = 1'b1; #1;
    chk("R1 mask", reg_rdata, 16'h0);
    reg_addr = 1'b0; #1;
    chk("R1 status", reg_rdata, 16'h0);
    // R2 live bank bits
    bank_req = 4'b1010; #1;
    chk("R2 bank", reg_rdata, 16'h000A);
    bank_req = 4'b0000;
    // R5 mask readback, unused bits zero
    wr(1'b1, 16'hFFFF); step("R5 wr");
    reg_addr = 1'b1; #1;
    chk("R5 readback", reg_rdata, 16'h83FF);
    reg_addr = 1'b0;
    // R3 sticky set, R6 irq follows
    src_pulse = 6'b000100; step("R3 set");
    chk("R3 bit6", reg_rdata, 16'h0040);
    step("R6 irq rise");
    chk("R6 high", {15'b0, host_irq}, 16'h1);
    step("R3 hold");
    // R8 retrigger: pend src0, clear src2, src0 remains
    src_pulse = 6'b000001; step("R8 pend");
    wr(1'b0, 16'h0040); step("R8 clear");
    chk("R8 low", {15'b0, host_irq}, 16'h0);
    step("R8 rerise");
    chk("R8 high", {15'b0, host_irq}, 16'h1);
    // R4 set wins over clear; bank bits and high bits unaffected
    src_pulse = 6'b000001; wr(1'b0, 16'hFC1F); step("R4 collide");
    chk("R4 set wins", reg_rdata, 16'h0010);
    wr(1'b0, 16'h0010); step("R4 clear");
    chk("R4 cleared", reg_rdata, 16'h0000);
    // R7 global enable off
    bank_req = 4'b0001; step("R7 pend");
    step("R7 pend2");
    wr(1'b1, 16'h03FF); step("R7 gen off");
    step("R7 low");
    chk("R7 low", {15'b0, host_irq}, 16'h0);
    // random mix
    for (int i = 0; i < 400; i++) begin
      bank_req = 4'($urandom);
      src_pulse = ($urandom % 4 == 0) ? 6'($urandom) : 6'b0;
      reg_addr = 1'($urandom);
      if ($urandom % 5 == 0) wr(1'($urandom), 16'($urandom));
      step("R6 random");
    end
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule